// File: doc/BRIEF.md
# Mask-to-Vector Broadcast Execution Unit

This execution unit takes one decoded micro-op per handshake, together with a 64-bit predicate mask read from the mask register file. It takes a small field of the mask, zero-extends it to the element width, and writes a copy into every element of a 512-bit destination vector. There are two variants. The byte variant fills 64-bit lanes with mask bits [7:0]. The word variant fills 32-bit lanes with mask bits [15:0]. The active vector length is chosen per micro-op. Every bit above the active length is driven to zero.

Illegal encodings do not produce a write. In their place the unit raises an undefined-instruction fault flag. Illegal encodings are an unknown opcode/width pairing, a reserved specifier field that is not all ones, and the reserved length code. The result, its write-enable and the fault flag are held in one output register stage with a valid/ready handshake. The unit also decodes the operand byte. It gives the mask read index to the register file combinationally, and it carries the destination vector register index along with the result.

Top module: `mask_bcast_unit`

## Requirements
- R1: Opcode 0x2A with width bit 1 selects the byte variant. Each active 64-bit lane (bits [64j+63:64j]) holds mask[7:0] in its low 8 bits and zeros above.
- R2: Opcode 0x3A with width bit 0 selects the word variant. Each active 32-bit lane (bits [32j+31:32j]) holds mask[15:0] in its low 16 bits and zeros above.
- R3: Length code 2'b00 activates 128 bits, 2'b01 activates 256 bits and 2'b10 activates 512 bits. This gives 2/4/8 lanes for the byte variant and 4/8/16 lanes for the word variant. Every output bit at or above the active length is 0.
- R4: If the 4-bit reserved specifier field is not 4'b1111, the result has out_fault=1, out_wen=0 and out_data all zero.
- R5: Length code 2'b11 raises out_fault with out_wen=0 and zero data.
- R6: Every opcode/width pair other than the two in R1 and R2 raises out_fault with out_wen=0 and zero data. This includes 0x2A with width 0 and 0x3A with width 1.
- R7: Mask bits above bit 15 never affect out_data. Mask bits above bit 7 do not affect the byte variant.
- R8: A micro-op accepted at a clock edge shows its result on the outputs after that edge, with out_valid=1. out_dst equals operand byte bits [5:3]. mask_rd_idx equals operand byte bits [2:0] combinationally.
- R9: in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, out_data, out_wen, out_fault and out_dst hold their values, and no new micro-op is taken.
- R10: While rst_n is low, out_valid, out_wen and out_fault are 0.
- R11: When out_valid=1, exactly one of out_wen and out_fault is 1. When a result is consumed and no new micro-op is accepted, out_valid, out_wen and out_fault all return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-op present |
| in_ready | output | 1 | Unit can take a micro-op |
| in_opcode | input | 8 | Opcode byte |
| in_w | input | 1 | Width bit |
| in_vl | input | 2 | Vector length code |
| in_vspec | input | 4 | Reserved register-specifier field |
| in_modrm | input | 8 | Operand byte: [5:3] destination, [2:0] mask source |
| mask_rd_idx | output | 3 | Mask register read index |
| in_mask | input | 64 | Mask source value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 512 | Destination vector |
| out_wen | output | 1 | Write destination |
| out_fault | output | 1 | Undefined-instruction fault |
| out_dst | output | 3 | Destination vector register index |

## Verification
The bench targets the lane boundaries at each length code. A unit that counts lanes in the wrong unit would leave a stray copy above 128 or 256 bits, or would clear a lane that should be filled. It sends a reserved-field value that is wrong in one bit only, the reserved length code, and the two crossed opcode/width pairs. A decoder that checks opcode alone, or that ignores the reserved field, would assert write-enable on an illegal op. It sets all upper mask bits to ones to expose a mask field taken too wide. It also holds back the result while a second op waits, to catch an output register that is overwritten during a stall.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_B2Q  = 2'd1,
      BC_W2D  = 2'd2
   } bc_kind_e;

   localparam logic [7:0] OPC_B2Q   = 8'h2A;
   localparam logic [7:0] OPC_W2D   = 8'h3A;
   localparam logic [3:0] VSPEC_OK  = 4'hF;
   localparam logic [1:0] VL_RSVD   = 2'b11;
   localparam int         BASE_BITS = 128;
   localparam int         MAX_BITS  = 512;
endpackage

// File: rtl/mbc_decode.sv
`timescale 1ns/1ps
module mbc_decode
   import mbc_pkg::*;
#(
   parameter int OPC_W   = 8,
   parameter int VSPEC_W = 4
) (
   input  logic [OPC_W-1:0]   opcode,
   input  logic               w_bit,
   input  logic [1:0]         vl_code,
   input  logic [VSPEC_W-1:0] vspec,
   output bc_kind_e           kind,
   output logic               legal
);
   generate
      if (OPC_W != 8) begin : g_bad_opc
         $error("mbc_decode: OPC_W must be 8");
      end
      if (VSPEC_W != 4) begin : g_bad_vspec
         $error("mbc_decode: VSPEC_W must be 4");
      end
   endgenerate

   always_comb begin
      kind = BC_NONE;
      if (opcode == OPC_B2Q && w_bit) begin
         kind = BC_B2Q;
      end else if (opcode == OPC_W2D && !w_bit) begin
         kind = BC_W2D;
      end
   end

   assign legal = (kind != BC_NONE) && (vspec == VSPEC_OK) && (vl_code != VL_RSVD);
endmodule

// File: rtl/mbc_lane_fill.sv
`timescale 1ns/1ps
module mbc_lane_fill
   import mbc_pkg::*;
#(
   parameter int VEC_W = 512
) (
   input  bc_kind_e         kind,
   input  logic [1:0]       vl_code,
   input  logic [15:0]      mask_lo,
   output logic [VEC_W-1:0] data
);
   localparam int CHUNK_W   = 32;
   localparam int N_CHUNK   = VEC_W / CHUNK_W;
   localparam int BASE_CHNK = BASE_BITS / CHUNK_W;

   generate
      if (VEC_W < MAX_BITS || (VEC_W % 64) != 0) begin : g_bad_vec
         $error("mbc_lane_fill: VEC_W must be a multiple of 64 and at least 512");
      end
   endgenerate

   logic [31:0] act_chunks;
   always_comb begin
      act_chunks = 32'(BASE_CHNK) << vl_code;
   end

   for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
      localparam int C = c;
      logic active;
      assign active = (act_chunks > 32'(C)) && (C < MAX_BITS / CHUNK_W);
      if ((C % 2) == 0) begin : g_even
         always_comb begin
            data[C*CHUNK_W +: CHUNK_W] = '0;
            if (active) begin
               case (kind)
                  BC_B2Q:  data[C*CHUNK_W +: CHUNK_W] = {24'd0, mask_lo[7:0]};
                  BC_W2D:  data[C*CHUNK_W +: CHUNK_W] = {16'd0, mask_lo};
                  default: data[C*CHUNK_W +: CHUNK_W] = '0;
               endcase
            end
         end
      end else begin : g_odd
         always_comb begin
            data[C*CHUNK_W +: CHUNK_W] = '0;
            if (active && kind == BC_W2D) begin
               data[C*CHUNK_W +: CHUNK_W] = {16'd0, mask_lo};
            end
         end
      end
   end
endmodule

// File: rtl/mbc_out_reg.sv
`timescale 1ns/1ps
module mbc_out_reg #(
   parameter int DATA_W = 512,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   output logic              acc_ready,
   input  logic              legal,
   input  logic [DATA_W-1:0] data_in,
   input  logic [IDX_W-1:0]  dst_in,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_wen,
   output logic              out_fault,
   output logic [IDX_W-1:0]  out_dst
);
   logic fire;
   assign acc_ready = !out_valid || out_ready;
   assign fire      = acc_valid && acc_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wen   <= 1'b0;
         out_fault <= 1'b0;
         out_data  <= '0;
         out_dst   <= '0;
      end else if (fire) begin
         out_valid <= 1'b1;
         out_wen   <= legal;
         out_fault <= !legal;
         out_data  <= legal ? data_in : '0;
         out_dst   <= dst_in;
      end else if (out_ready) begin
         out_valid <= 1'b0;
         out_wen   <= 1'b0;
         out_fault <= 1'b0;
      end
   end
endmodule

// File: rtl/mask_bcast_unit.sv
`timescale 1ns/1ps
module mask_bcast_unit
   import mbc_pkg::*;
#(
   parameter int VEC_W  = 512,
   parameter int MASK_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_opcode,
   input  logic              in_w,
   input  logic [1:0]        in_vl,
   input  logic [3:0]        in_vspec,
   input  logic [7:0]        in_modrm,
   output logic [IDX_W-1:0]  mask_rd_idx,
   input  logic [MASK_W-1:0] in_mask,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [VEC_W-1:0]  out_data,
   output logic              out_wen,
   output logic              out_fault,
   output logic [IDX_W-1:0]  out_dst
);
   generate
      if (MASK_W < 16) begin : g_bad_mask
         $error("mask_bcast_unit: MASK_W must be at least 16");
      end
      if (IDX_W != 3) begin : g_bad_idx
         $error("mask_bcast_unit: IDX_W must be 3");
      end
   endgenerate

   bc_kind_e         kind;
   logic             legal;
   logic [VEC_W-1:0] fill;
   logic             unused_bits;

   assign unused_bits = ^{in_mask[MASK_W-1:16], in_modrm[7:6]};
   assign mask_rd_idx = in_modrm[2:0];

   mbc_decode #(.OPC_W(8), .VSPEC_W(4)) u_dec (
      .opcode (in_opcode),
      .w_bit  (in_w),
      .vl_code(in_vl),
      .vspec  (in_vspec),
      .kind   (kind),
      .legal  (legal)
   );

   mbc_lane_fill #(.VEC_W(VEC_W)) u_fill (
      .kind   (kind),
      .vl_code(in_vl),
      .mask_lo(in_mask[15:0]),
      .data   (fill)
   );

   mbc_out_reg #(.DATA_W(VEC_W), .IDX_W(IDX_W)) u_oreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_valid(in_valid),
      .acc_ready(in_ready),
      .legal    (legal),
      .data_in  (fill),
      .dst_in   (in_modrm[5:3]),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_wen  (out_wen),
      .out_fault(out_fault),
      .out_dst  (out_dst)
   );
endmodule

// File: rtl/mbc_checker.sv
`timescale 1ns/1ps
module mbc_checker #(
   parameter int VEC_W  = 512,
   parameter int MASK_W = 64,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [7:0]        in_opcode,
   input logic              in_w,
   input logic [1:0]        in_vl,
   input logic [3:0]        in_vspec,
   input logic [MASK_W-1:0] in_mask,
   input logic              out_valid,
   input logic              out_ready,
   input logic [VEC_W-1:0]  out_data,
   input logic              out_wen,
   input logic              out_fault,
   input logic [IDX_W-1:0]  out_dst
);
   logic fire, ok_common;
   assign fire      = in_valid && in_ready;
   assign ok_common = (in_vspec == 4'hF) && (in_vl != 2'b11);

   assert_byte_lane0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire && ok_common && in_opcode == 8'h2A && in_w
      |=> out_wen && out_data[63:0] == {56'd0, $past(in_mask[7:0])});

   assert_word_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && ok_common && in_opcode == 8'h3A && !in_w
      |=> out_wen && out_data[31:0] == {16'd0, $past(in_mask[15:0])});

   assert_len128_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && in_vl == 2'b00 |=> out_data[VEC_W-1:128] == '0);

   assert_vspec_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && in_vspec != 4'hF |=> out_fault && !out_wen && out_data == '0);

   assert_vl_rsvd_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && in_vl == 2'b11 |=> out_fault && !out_wen);

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready
      |=> out_valid && $stable(out_data) && $stable(out_wen) && $stable(out_fault) && $stable(out_dst));

   assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (!out_valid || out_ready));

   assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({out_wen, out_fault}) == 1);

   assert_idle_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_wen && !out_fault);
endmodule

bind mask_bcast_unit mbc_checker #(.VEC_W(VEC_W), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_opcode(in_opcode),
   .in_w     (in_w),
   .in_vl    (in_vl),
   .in_vspec (in_vspec),
   .in_mask  (in_mask),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_wen  (out_wen),
   .out_fault(out_fault),
   .out_dst  (out_dst)
);

// File: tb/mask_bcast_unit_test.sv
`timescale 1ns/1ps
module mask_bcast_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [7:0]   in_opcode = 8'h00;
   logic         in_w = 1'b0;
   logic [1:0]   in_vl = 2'b00;
   logic [3:0]   in_vspec = 4'hF;
   logic [7:0]   in_modrm = 8'h00;
   logic [2:0]   mask_rd_idx;
   logic [63:0]  in_mask = 64'd0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [511:0] out_data;
   logic         out_wen;
   logic         out_fault;
   logic [2:0]   out_dst;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2.5 clk = ~clk;

   mask_bcast_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_opcode(in_opcode), .in_w(in_w), .in_vl(in_vl), .in_vspec(in_vspec),
      .in_modrm(in_modrm), .mask_rd_idx(mask_rd_idx), .in_mask(in_mask),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_wen(out_wen), .out_fault(out_fault), .out_dst(out_dst)
   );

   function automatic logic [511:0] model(int kind, logic [1:0] vl, logic [63:0] m);
      logic [511:0] r = '0;
      if (kind == 1) begin
         for (int j = 0; j < (2 << vl); j++) r[j*64 +: 64] = {56'd0, m[7:0]};
      end else if (kind == 2) begin
         for (int j = 0; j < (4 << vl); j++) r[j*32 +: 32] = {16'd0, m[15:0]};
      end
      return r;
   endfunction

   task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic [7:0] op, logic w, logic [1:0] vl, logic [3:0] vs,
                        logic [7:0] mr, logic [63:0] m);
      in_opcode = op; in_w = w; in_vl = vl; in_vspec = vs; in_modrm = mr; in_mask = m;
   endtask

   // drive at a falling edge, accepted at the next rising edge, sampled at the falling edge after
   task automatic send(logic [7:0] op, logic w, logic [1:0] vl, logic [3:0] vs,
                       logic [7:0] mr, logic [63:0] m);
      @(negedge clk);
      drive(op, w, vl, vs, mr, m);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 valid", 512'(out_valid), 512'd0);
      chk("R10 wen", 512'(out_wen), 512'd0);
      chk("R10 fault", 512'(out_fault), 512'd0);
   endtask

   task automatic t_byte();
      logic [63:0] m = 64'hFFFF_FFFF_FFFF_A5C3;
      for (int v = 0; v < 3; v++) begin
         send(8'h2A, 1'b1, 2'(v), 4'hF, 8'h08, m);
         chk("R1 byte data", out_data, model(1, 2'(v), m));
         chk("R3 byte length", 512'({out_valid, out_wen, out_fault}), 512'd6);
      end
   endtask

   task automatic t_word();
      logic [63:0] m = 64'h1234_5678_9ABC_8E71;
      for (int v = 0; v < 3; v++) begin
         send(8'h3A, 1'b0, 2'(v), 4'hF, 8'h10, m);
         chk("R2 word data", out_data, model(2, 2'(v), m));
         chk("R3 word length", 512'({out_valid, out_wen, out_fault}), 512'd6);
      end
   endtask

   task automatic t_vspec();
      send(8'h3A, 1'b0, 2'b10, 4'hE, 8'h00, 64'hFFFF);
      chk("R4 fault flags", 512'({out_valid, out_wen, out_fault}), 512'd5);
      chk("R4 zero data", out_data, 512'd0);
      send(8'h2A, 1'b1, 2'b01, 4'h7, 8'h00, 64'hFF);
      chk("R4 byte fault", 512'({out_wen, out_fault}), 512'd1);
   endtask

   task automatic t_vl_rsvd();
      send(8'h2A, 1'b1, 2'b11, 4'hF, 8'h00, 64'h5A);
      chk("R5 fault flags", 512'({out_valid, out_wen, out_fault}), 512'd5);
      chk("R5 zero data", out_data, 512'd0);
   endtask

   task automatic t_bad_op();
      send(8'h2A, 1'b0, 2'b00, 4'hF, 8'h00, 64'h11);
      chk("R6 2A w0", 512'({out_wen, out_fault}), 512'd1);
      send(8'h3A, 1'b1, 2'b00, 4'hF, 8'h00, 64'h11);
      chk("R6 3A w1", 512'({out_wen, out_fault}), 512'd1);
      send(8'h2B, 1'b1, 2'b10, 4'hF, 8'h00, 64'h11);
      chk("R6 other opcode", 512'({out_wen, out_fault, |out_data}), 512'd2);
   endtask

   task automatic t_mask_upper();
      send(8'h2A, 1'b1, 2'b10, 4'hF, 8'h00, 64'hFFFF_FFFF_FFFF_FF3C);
      chk("R7 byte upper ignored", out_data, model(1, 2'b10, 64'h3C));
      send(8'h3A, 1'b0, 2'b10, 4'hF, 8'h00, 64'hDEAD_BEEF_0000_4321);
      chk("R7 word upper ignored", out_data, model(2, 2'b10, 64'h4321));
   endtask

   task automatic t_latency();
      @(negedge clk);
      drive(8'h3A, 1'b0, 2'b00, 4'hF, 8'b11_101_110, 64'h0042);
      in_valid = 1'b1;
      #1;
      chk("R8 mask index", 512'(mask_rd_idx), 512'd6);
      chk("R8 not yet valid", 512'(out_valid), 512'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 valid after edge", 512'(out_valid), 512'd1);
      chk("R8 dst index", 512'(out_dst), 512'd5);
   endtask

   task automatic t_stall();
      logic [511:0] first;
      @(negedge clk);
      out_ready = 1'b0;
      drive(8'h2A, 1'b1, 2'b10, 4'hF, 8'b00_011_001, 64'h77);
      in_valid = 1'b1;
      @(negedge clk);
      first = model(1, 2'b10, 64'h77);
      drive(8'h3A, 1'b0, 2'b10, 4'hE, 8'b00_110_001, 64'h99);
      #1;
      chk("R9 ready low when stalled", 512'(in_ready), 512'd0);
      @(negedge clk);
      chk("R9 data held", out_data, first);
      chk("R9 flags held", 512'({out_valid, out_wen, out_fault, out_dst}), 512'({3'b110, 3'd3}));
      in_valid  = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      chk("R11 idle after consume", 512'({out_valid, out_wen, out_fault}), 512'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_byte();
      t_word();
      t_vspec();
      t_vl_rsvd();
      t_bad_op();
      t_mask_upper();
      @(negedge clk);
      t_latency();
      @(negedge clk);
      t_stall();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule